// File: doc/BRIEF.md
# Character-Cell Text Overlay Compositor

This block sits in a video pipeline and lays a grid of text characters over the incoming pixel stream. Each input pixel arrives with its coordinate inside the active image and with valid and sync flags. The block tests whether the pixel lies inside a rectangular overlay window. If it does, the block finds the character cell, reads that cell's 16-bit word from an internal character memory and looks up one row of a built-in glyph. The output pixel is then the glyph colour where the glyph is lit. Elsewhere inside the window it is the background pixel passed through a selectable filter.

Software sets the block up through a small register bus. The registers cover the window origin, the grid size, the background filter, the display mode and the active resolution. A separate write port fills the character memory. The output is registered, and the valid and sync flags travel alongside the pixel so that all of them stay aligned.

Top module: `txt_overlay`

## Requirements
- R1: Address 0 reads the constant major*100+minor (105 by default) and address 1 reads the capability word, with (max columns - 1) in bits [13:8] and (max rows - 1) in bits [4:0] (0x3F1F by default). Writes to either address are ignored.
- R2: Address 2 holds the control word: filter in [1:0], mode in [4:3], enable in [6] and resolution select in [10:8]. Address 3 holds (columns-1) in [13:8] and (rows-1) in [4:0]. Addresses 4 and 5 hold the window's X and Y origin in pixels. Each of these reads back what was written, with undefined bits read as zero.
- R3: pix_o, valid_o, hs_o and vs_o are the result for the inputs sampled exactly two clock edges earlier.
- R4: A pixel is composited only if all of the following hold: xo <= x < xo+12*cols, yo <= y < yo+18*rows, and (x,y) lies inside the active size. The active size is 720x400 for select 1, 1024x768 for select 2, and 640x480 for any other value. Every other pixel leaves unchanged.
- R5: Inside the window, col=(x-xo)/12 and gx=(x-xo)%12, row=(y-yo)/18 and gy=(y-yo)%18. The memory word index is row*cols+col. The word's bits [15:8] are the character code and bits [7:0] are its attribute.
- R6: A glyph pixel is lit when all of these hold: 1<=gx<=10, 1<=gy<=16, and bit ((gx+gy) mod 8) of the character code is 1.
- R7: A lit pixel outputs the attribute colour a, with red {a[7:5],a[7:5],a[7:6]}, green {a[4:2],a[4:2],a[4:3]} and blue {4{a[1:0]}}. Red sits in pix bits [23:16], green in [15:8] and blue in [7:0].
- R8: An unlit pixel inside the window outputs the filtered background. Filter 0 gives black, 1 gives the original, 2 halves each channel (rounding down), and 3 sets every channel to floor((R+G+B)/3).
- R9: Modes 0 and 3 pass every pixel through unchanged. Mode 1 composites whatever the enable bit is. Mode 2 composites only while enable is 1.
- R10: A character memory write whose index is >= cols*rows, under the grid in force at that edge, is ignored.
- R11: When a pixel's fetch and a write to the same memory word fall on the same edge, that pixel sees the old word, and the next fetch sees the new one.
- R12: While reset is asserted, and after it, all outputs and all writable registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for reg_addr_i |
| cm_we_i | input | 1 | Character memory write strobe |
| cm_addr_i | input | 11 | Character memory word index |
| cm_wdata_i | input | 16 | Character word: code [15:8], attribute [7:0] |
| pix_i | input | 24 | Input pixel, R/G/B |
| valid_i | input | 1 | Input pixel valid |
| hs_i | input | 1 | Input horizontal sync |
| vs_i | input | 1 | Input vertical sync |
| x_i | input | 11 | Active-area column of pix_i |
| y_i | input | 11 | Active-area row of pix_i |
| pix_o | output | 24 | Composited pixel |
| valid_o | output | 1 | Delayed valid |
| hs_o | output | 1 | Delayed horizontal sync |
| vs_o | output | 1 | Delayed vertical sync |

## Verification
A character memory write and the pixel fetch of that same word can land on the same edge. The bench provokes this by holding the pixel on a lit glyph position of cell 1 while it rewrites cell 1 with a blank code in that very cycle. The reference model then expects the old glyph colour for that pixel and the filtered background for the one after it. Register writes that change the grid or mode while pixels stream are judged the same way: the model applies every write only after it has computed the pixel sampled on that edge.

// File: rtl/txo_pkg.sv
package txo_pkg;
  localparam int unsigned CELL_W = 12;
  localparam int unsigned CELL_H = 18;

  typedef enum logic [1:0] {FLT_BLACK = 2'd0, FLT_ORIG = 2'd1, FLT_DARK = 2'd2, FLT_GRAY = 2'd3} filt_e;
  typedef enum logic [1:0] {MD_PASS = 2'd0, MD_OVL = 2'd1, MD_AUTO = 2'd2, MD_OFF = 2'd3} mode_e;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  localparam logic [2:0] A_VER  = 3'd0;
  localparam logic [2:0] A_FEAT = 3'd1;
  localparam logic [2:0] A_CTRL = 3'd2;
  localparam logic [2:0] A_GRID = 3'd3;
  localparam logic [2:0] A_XPOS = 3'd4;
  localparam logic [2:0] A_YPOS = 3'd5;

  function automatic logic [15:0] act_w(input logic [2:0] s);
    case (s)
      3'd1:    return 16'd720;
      3'd2:    return 16'd1024;
      default: return 16'd640;
    endcase
  endfunction

  function automatic logic [15:0] act_h(input logic [2:0] s);
    case (s)
      3'd1:    return 16'd400;
      3'd2:    return 16'd768;
      default: return 16'd480;
    endcase
  endfunction
endpackage

// File: rtl/txo_regs.sv
module txo_regs import txo_pkg::*; #(
  parameter int unsigned MAX_COLS  = 64,
  parameter int unsigned MAX_ROWS  = 32,
  parameter int unsigned VER_MAJOR = 1,
  parameter int unsigned VER_MINOR = 5,
  localparam int unsigned CW = $clog2(MAX_COLS),
  localparam int unsigned RW = $clog2(MAX_ROWS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [2:0]    addr_i,
  input  logic [15:0]   wdata_i,
  output logic [15:0]   rdata_o,
  output filt_e         filt_o,
  output mode_e         mode_o,
  output logic          en_o,
  output logic [2:0]    sync_o,
  output logic [CW-1:0] ncm1_o,
  output logic [RW-1:0] nrm1_o,
  output logic [15:0]   xpos_o,
  output logic [15:0]   ypos_o
);
  localparam logic [15:0] VER_VAL  = 16'(VER_MAJOR * 100 + VER_MINOR);
  localparam logic [15:0] FEAT_VAL = (16'(MAX_COLS - 1) << 8) | 16'(MAX_ROWS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_o <= FLT_BLACK;
      mode_o <= MD_PASS;
      en_o   <= 1'b0;
      sync_o <= 3'd0;
      ncm1_o <= '0;
      nrm1_o <= '0;
      xpos_o <= '0;
      ypos_o <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_CTRL: begin
          filt_o <= filt_e'(wdata_i[1:0]);
          mode_o <= mode_e'(wdata_i[4:3]);
          en_o   <= wdata_i[6];
          sync_o <= wdata_i[10:8];
        end
        A_GRID: begin
          ncm1_o <= wdata_i[8 +: CW];
          nrm1_o <= wdata_i[0 +: RW];
        end
        A_XPOS:  xpos_o <= wdata_i;
        A_YPOS:  ypos_o <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      A_VER:   rdata_o = VER_VAL;
      A_FEAT:  rdata_o = FEAT_VAL;
      A_CTRL:  rdata_o = {5'b0, sync_o, 1'b0, en_o, 1'b0, mode_o, 1'b0, filt_o};
      A_GRID:  rdata_o = (16'(ncm1_o) << 8) | 16'(nrm1_o);
      A_XPOS:  rdata_o = xpos_o;
      A_YPOS:  rdata_o = ypos_o;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/txo_charmem.sv
module txo_charmem #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 16,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  // read-before-write: a same-edge fetch returns the old word
  always_ff @(posedge clk_i) begin
    rdata_o <= mem_q[raddr_i];
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end
endmodule

// File: rtl/txo_glyph.sv
module txo_glyph import txo_pkg::*; (
  input  logic [7:0]        code_i,
  input  logic [4:0]        gy_i,
  output logic [CELL_W-1:0] row_o
);
  logic gy_in;
  assign gy_in = (gy_i >= 5'd1) && (gy_i <= 5'(CELL_H - 2));

  for (genvar g = 0; g < CELL_W; g++) begin : g_px
    if (g == 0 || g == CELL_W - 1) begin : g_edge
      assign row_o[g] = 1'b0;
    end else begin : g_body
      logic [2:0] sel;
      assign sel = gy_i[2:0] + 3'(g);
      assign row_o[g] = gy_in && code_i[sel];
    end
  end
endmodule

// File: rtl/txo_filter.sv
module txo_filter import txo_pkg::*; (
  input  rgb_t  bg_i,
  input  filt_e filt_i,
  output rgb_t  bg_o
);
  logic [9:0]  sum;
  logic [19:0] prod;
  logic [7:0]  avg;

  // floor(sum/3) for sum <= 765 via multiply by 683 / 2048
  assign sum  = 10'(bg_i.r) + 10'(bg_i.g) + 10'(bg_i.b);
  assign prod = 20'(sum) * 20'd683;
  assign avg  = 8'(prod >> 11);

  always_comb begin
    case (filt_i)
      FLT_BLACK: bg_o = '0;
      FLT_ORIG:  bg_o = bg_i;
      FLT_DARK:  bg_o = '{r: bg_i.r >> 1, g: bg_i.g >> 1, b: bg_i.b >> 1};
      default:   bg_o = '{r: avg, g: avg, b: avg};
    endcase
  end
endmodule

// File: rtl/txt_overlay.sv
module txt_overlay import txo_pkg::*; #(
  parameter int unsigned MAX_COLS  = 64,
  parameter int unsigned MAX_ROWS  = 32,
  parameter int unsigned VER_MAJOR = 1,
  parameter int unsigned VER_MINOR = 5,
  parameter int unsigned COORD_W   = 11,
  localparam int unsigned CW = $clog2(MAX_COLS),
  localparam int unsigned RW = $clog2(MAX_ROWS),
  localparam int unsigned AW = CW + RW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [2:0]         reg_addr_i,
  input  logic [15:0]        reg_wdata_i,
  output logic [15:0]        reg_rdata_o,
  input  logic               cm_we_i,
  input  logic [AW-1:0]      cm_addr_i,
  input  logic [15:0]        cm_wdata_i,
  input  logic [23:0]        pix_i,
  input  logic               valid_i,
  input  logic               hs_i,
  input  logic               vs_i,
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  output logic [23:0]        pix_o,
  output logic               valid_o,
  output logic               hs_o,
  output logic               vs_o
);
  filt_e         filt_q;
  mode_e         mode_q;
  logic          en_q;
  logic [2:0]    sync_q;
  logic [CW-1:0] ncm1_q;
  logic [RW-1:0] nrm1_q;
  logic [15:0]   xpos_q, ypos_q;

  txo_regs #(
    .MAX_COLS(MAX_COLS), .MAX_ROWS(MAX_ROWS),
    .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .filt_o(filt_q), .mode_o(mode_q), .en_o(en_q), .sync_o(sync_q),
    .ncm1_o(ncm1_q), .nrm1_o(nrm1_q), .xpos_o(xpos_q), .ypos_o(ypos_q)
  );

  // ---- stage 0: window and cell arithmetic
  logic [CW:0]        ncols;
  logic [RW:0]        nrows;
  logic [AW:0]        cells;
  logic [16:0]        win_w, win_h, xs, ys, xe, ye, x17, y17;
  logic               in_x, in_y, show;
  logic [COORD_W-1:0] rel_x, rel_y;
  logic [CW-1:0]      col;
  logic [RW-1:0]      row;
  logic [3:0]         gx;
  logic [4:0]         gy;
  logic [AW-1:0]      raddr;
  logic               wr_ok;

  assign ncols = (CW+1)'(ncm1_q) + (CW+1)'(1);
  assign nrows = (RW+1)'(nrm1_q) + (RW+1)'(1);
  assign cells = (AW+1)'(ncols) * (AW+1)'(nrows);
  assign win_w = 17'(ncols) * 17'(CELL_W);
  assign win_h = 17'(nrows) * 17'(CELL_H);
  assign xs    = 17'(xpos_q);
  assign ys    = 17'(ypos_q);
  assign xe    = xs + win_w;
  assign ye    = ys + win_h;
  assign x17   = 17'(x_i);
  assign y17   = 17'(y_i);

  assign in_x = (x17 >= xs) && (x17 < xe) && (16'(x_i) < act_w(sync_q));
  assign in_y = (y17 >= ys) && (y17 < ye) && (16'(y_i) < act_h(sync_q));
  assign show = (mode_q == MD_OVL) || ((mode_q == MD_AUTO) && en_q);

  assign rel_x = x_i - COORD_W'(xpos_q);
  assign rel_y = y_i - COORD_W'(ypos_q);
  assign col   = CW'(rel_x / COORD_W'(CELL_W));
  assign gx    = 4'(rel_x % COORD_W'(CELL_W));
  assign row   = RW'(rel_y / COORD_W'(CELL_H));
  assign gy    = 5'(rel_y % COORD_W'(CELL_H));
  assign raddr = AW'((AW+1)'(row) * (AW+1)'(ncols) + (AW+1)'(col));
  assign wr_ok = cm_we_i && ((AW+1)'(cm_addr_i) < cells);

  logic [15:0] word_q;

  txo_charmem #(.AW(AW), .DW(16)) u_mem (
    .clk_i,
    .we_i(wr_ok), .waddr_i(cm_addr_i), .wdata_i(cm_wdata_i),
    .raddr_i(raddr), .rdata_o(word_q)
  );

  // ---- stage 1 registers
  rgb_t  s1_pix;
  logic  s1_valid, s1_hs, s1_vs, s1_win;
  logic [3:0] s1_gx;
  logic [4:0] s1_gy;
  filt_e s1_filt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_pix   <= '0;
      s1_valid <= 1'b0;
      s1_hs    <= 1'b0;
      s1_vs    <= 1'b0;
      s1_win   <= 1'b0;
      s1_gx    <= '0;
      s1_gy    <= '0;
      s1_filt  <= FLT_BLACK;
    end else begin
      s1_pix   <= rgb_t'(pix_i);
      s1_valid <= valid_i;
      s1_hs    <= hs_i;
      s1_vs    <= vs_i;
      s1_win   <= show && in_x && in_y;
      s1_gx    <= gx;
      s1_gy    <= gy;
      s1_filt  <= filt_q;
    end
  end

  // ---- stage 2: glyph, colour, filter
  logic [CELL_W-1:0] grow;
  logic              lit;
  rgb_t              fg, bg_f, res;

  txo_glyph u_glyph (.code_i(word_q[15:8]), .gy_i(s1_gy), .row_o(grow));
  txo_filter u_filt (.bg_i(s1_pix), .filt_i(s1_filt), .bg_o(bg_f));

  assign lit  = grow[s1_gx];
  assign fg.r = {word_q[7:5], word_q[7:5], word_q[7:6]};
  assign fg.g = {word_q[4:2], word_q[4:2], word_q[4:3]};
  assign fg.b = {4{word_q[1:0]}};

  always_comb begin
    if (!s1_win)  res = s1_pix;
    else if (lit) res = fg;
    else          res = bg_f;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o   <= '0;
      valid_o <= 1'b0;
      hs_o    <= 1'b0;
      vs_o    <= 1'b0;
    end else begin
      pix_o   <= res;
      valid_o <= s1_valid;
      hs_o    <= s1_hs;
      vs_o    <= s1_vs;
    end
  end
endmodule

// File: rtl/txo_checker.sv
module txo_checker #(
  parameter int unsigned COORD_W = 11
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [23:0]        pix_i,
  input logic               valid_i,
  input logic               hs_i,
  input logic               vs_i,
  input logic [COORD_W-1:0] x_i,
  input logic [COORD_W-1:0] y_i,
  input logic [23:0]        pix_o,
  input logic               valid_o,
  input logic               hs_o,
  input logic               vs_o,
  input logic [1:0]         mode,
  input logic [15:0]        xpos,
  input logic [15:0]        ypos
);
  logic [1:0] age;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  AST_VALID_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd3) |-> (valid_o == $past(valid_i, 2))); // R3
  AST_SYNC_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd3) |-> (hs_o == $past(hs_i, 2) && vs_o == $past(vs_i, 2))); // R3
  AST_PASS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd3 && ($past(mode, 2) == 2'd0 || $past(mode, 2) == 2'd3))
      |-> (pix_o == $past(pix_i, 2))); // R9
  AST_LEFT_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd3 && 17'($past(x_i, 2)) < 17'($past(xpos, 2)))
      |-> (pix_o == $past(pix_i, 2))); // R4
  AST_TOP_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd3 && 17'($past(y_i, 2)) < 17'($past(ypos, 2)))
      |-> (pix_o == $past(pix_i, 2))); // R4
endmodule

bind txt_overlay txo_checker #(.COORD_W(COORD_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .pix_i(pix_i), .valid_i(valid_i), .hs_i(hs_i), .vs_i(vs_i),
  .x_i(x_i), .y_i(y_i),
  .pix_o(pix_o), .valid_o(valid_o), .hs_o(hs_o), .vs_o(vs_o),
  .mode(mode_q), .xpos(xpos_q), .ypos(ypos_q)
);

// File: tb/txt_overlay_tb.sv
module txt_overlay_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCELL = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        cm_we = 1'b0;
  logic [10:0] cm_addr = '0;
  logic [15:0] cm_wdata = '0;
  logic [23:0] pix_i = '0;
  logic        valid_i = 1'b0, hs_i = 1'b0, vs_i = 1'b0;
  logic [10:0] x_i = '0, y_i = '0;
  logic [23:0] pix_o;
  logic        valid_o, hs_o, vs_o;

  int n_chk = 0;
  int n_err = 0;
  string cur_req = "R12";
  bit chk_en = 1'b0;

  txt_overlay u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .cm_we_i(cm_we), .cm_addr_i(cm_addr), .cm_wdata_i(cm_wdata),
    .pix_i(pix_i), .valid_i(valid_i), .hs_i(hs_i), .vs_i(vs_i), .x_i(x_i), .y_i(y_i),
    .pix_o(pix_o), .valid_o(valid_o), .hs_o(hs_o), .vs_o(vs_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model
  int m_filt, m_mode, m_en, m_sync, m_cols, m_rows, m_xpos, m_ypos;
  int m_mem [NCELL];
  int e1_pix, e1_v, e1_h, e1_s;
  int ex_pix, ex_v, ex_h, ex_s;

  function automatic int ref_pix(int x, int y, int p);
    int w, h, rx, ry, c, r, gx, gy, wd, code, a, lit, rr, gg, bb, av;
    case (m_sync)
      1: begin w = 720;  h = 400; end
      2: begin w = 1024; h = 768; end
      default: begin w = 640; h = 480; end
    endcase
    if (!(m_mode == 1 || (m_mode == 2 && m_en == 1))) return p;
    if (x < m_xpos || x >= m_xpos + 12 * m_cols || x >= w) return p;
    if (y < m_ypos || y >= m_ypos + 18 * m_rows || y >= h) return p;
    rx = x - m_xpos; ry = y - m_ypos;
    c = rx / 12; gx = rx % 12; r = ry / 18; gy = ry % 18;
    wd = m_mem[r * m_cols + c];
    code = wd / 256; a = wd % 256;
    lit = (gx >= 1 && gx <= 10 && gy >= 1 && gy <= 16 && ((code >> ((gx + gy) % 8)) & 1) == 1) ? 1 : 0;
    if (lit == 1) begin
      rr = ((a >> 5) & 7); rr = rr * 32 + rr * 4 + rr / 2;
      gg = ((a >> 2) & 7); gg = gg * 32 + gg * 4 + gg / 2;
      bb = (a & 3) * 85;
      return rr * 65536 + gg * 256 + bb;
    end
    rr = (p >> 16) & 255; gg = (p >> 8) & 255; bb = p & 255;
    case (m_filt)
      0: return 0;
      1: return p;
      2: return (rr / 2) * 65536 + (gg / 2) * 256 + bb / 2;
      default: begin av = (rr + gg + bb) / 3; return av * 65793; end
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_filt = 0; m_mode = 0; m_en = 0; m_sync = 0; m_cols = 1; m_rows = 1; m_xpos = 0; m_ypos = 0;
      e1_pix = 0; e1_v = 0; e1_h = 0; e1_s = 0;
      ex_pix = 0; ex_v = 0; ex_h = 0; ex_s = 0;
    end else begin
      ex_pix = e1_pix; ex_v = e1_v; ex_h = e1_h; ex_s = e1_s;
      e1_pix = ref_pix(int'(x_i), int'(y_i), int'(pix_i));
      e1_v = int'(valid_i); e1_h = int'(hs_i); e1_s = int'(vs_i);
      if (reg_we) begin
        case (int'(reg_addr))
          2: begin
            m_filt = reg_wdata & 3; m_mode = (reg_wdata >> 3) & 3;
            m_en = (reg_wdata >> 6) & 1; m_sync = (reg_wdata >> 8) & 7;
          end
          3: begin m_cols = ((reg_wdata >> 8) & 63) + 1; m_rows = (reg_wdata & 31) + 1; end
          4: m_xpos = int'(reg_wdata);
          5: m_ypos = int'(reg_wdata);
          default: ;
        endcase
      end
      if (cm_we && int'(cm_addr) < m_cols * m_rows) m_mem[cm_addr] = int'(cm_wdata);
    end
  end

  always @(negedge clk) begin
    if (rst_n && chk_en) begin
      n_chk++;
      if (int'(pix_o) != ex_pix || int'(valid_o) != ex_v || int'(hs_o) != ex_h || int'(vs_o) != ex_s) begin
        n_err++;
        $display("FAIL %s: pix=%h v/h/s=%b%b%b expected pix=%h v/h/s=%0d%0d%0d",
                 cur_req, pix_o, valid_o, hs_o, vs_o, ex_pix[23:0], ex_v, ex_h, ex_s);
      end
    end
  end

  // ---------------- tasks
  task automatic reg_wr(input int a, input int d);
    @(negedge clk); reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 16'(d);
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic cm_wr(input int a, input int d);
    @(negedge clk); cm_we = 1'b1; cm_addr = 11'(a); cm_wdata = 16'(d);
    @(negedge clk); cm_we = 1'b0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string tag);
    @(negedge clk); reg_addr = 3'(a); #1;
    n_chk++;
    if (int'(reg_rdata) != exp) begin
      n_err++;
      $display("FAIL %s: reg %0d read %h expected %h", tag, a, reg_rdata, exp[15:0]);
    end
  endtask

  function automatic int pat(int x, int y);
    return ((x * 7 + y) & 255) * 65536 + ((y * 13 + 40) & 255) * 256 + ((x * 3 + y * 5) & 255);
  endfunction

  task automatic scan(input int x0, input int x1, input int y0, input int y1);
    for (int y = y0; y <= y1; y++) begin
      for (int x = x0; x <= x1; x++) begin
        @(negedge clk);
        x_i = 11'(x); y_i = 11'(y); pix_i = 24'(pat(x, y));
        valid_i = (x % 5 != 0); hs_i = (x == x0); vs_i = (x == x0 && y == y0);
      end
    end
    @(negedge clk); valid_i = 1'b0; hs_i = 1'b0; vs_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: outputs during reset
    n_chk++;
    if (pix_o !== 24'd0 || valid_o !== 1'b0 || hs_o !== 1'b0 || vs_o !== 1'b0) begin
      n_err++;
      $display("FAIL R12: outputs %h %b%b%b expected 000000 000", pix_o, valid_o, hs_o, vs_o);
    end
    rst_n = 1'b1;
    chk_en = 1'b1;
    rd_chk(2, 16'h0000, "R12");
    rd_chk(3, 16'h0000, "R12");
    rd_chk(4, 16'h0000, "R12");
    rd_chk(0, 105, "R1");
    rd_chk(1, 16'h3F1F, "R1");
    reg_wr(0, 16'h1234);
    reg_wr(1, 16'hFFFF);
    rd_chk(0, 105, "R1");
    rd_chk(1, 16'h3F1F, "R1");
    reg_wr(2, 16'hFFFF);
    rd_chk(2, 16'h075B, "R2");
    reg_wr(3, 16'hFFFF);
    rd_chk(3, 16'h3F1F, "R2");
    reg_wr(4, 16'hBEEF);
    rd_chk(4, 16'hBEEF, "R2");
    reg_wr(5, 16'h0123);
    rd_chk(5, 16'h0123, "R2");
    rd_chk(6, 0, "R2");

    // fill whole memory under 64x32 grid
    cur_req = "R10";
    reg_wr(2, 16'h0000);
    for (int i = 0; i < NCELL; i++) cm_wr(i, ((i * 37 + 5) & 255) * 256 + ((i * 11 + 3) & 255));

    // R9: passthrough and off ignore the window
    cur_req = "R9 passthrough";
    reg_wr(3, (7 << 8) | 2); reg_wr(4, 20); reg_wr(5, 10);
    reg_wr(2, 16'h0041);
    scan(10, 70, 5, 30);
    cur_req = "R9 off";
    reg_wr(2, 16'h0059);
    scan(10, 70, 5, 30);

    // R5 R6 R7 R8 R3: overlay mode with original filter
    cur_req = "R5 R6 R7 R3 overlay original";
    reg_wr(2, 16'h0009);
    scan(10, 125, 5, 70);
    cur_req = "R8 black";
    reg_wr(2, 16'h0008);
    scan(15, 60, 8, 40);
    cur_req = "R8 darker";
    reg_wr(2, 16'h000A);
    scan(15, 60, 8, 40);
    cur_req = "R8 gray";
    reg_wr(2, 16'h000B);
    scan(15, 60, 8, 40);

    // R9 auto: enable gates the overlay
    cur_req = "R9 auto off";
    reg_wr(2, 16'h0011);
    scan(18, 60, 8, 32);
    cur_req = "R9 auto on";
    reg_wr(2, 16'h0051);
    scan(18, 60, 8, 32);

    // R4: active-size clipping by resolution select
    cur_req = "R4 select 640";
    reg_wr(3, (7 << 8) | 0); reg_wr(4, 600); reg_wr(5, 0);
    reg_wr(2, 16'h0009);
    scan(590, 700, 0, 19);
    cur_req = "R4 select 1024";
    reg_wr(2, 16'h0209);
    scan(590, 700, 0, 19);
    cur_req = "R4 select 720 bottom";
    reg_wr(3, (3 << 8) | 31); reg_wr(4, 0); reg_wr(5, 380);
    reg_wr(2, 16'h0109);
    scan(0, 50, 370, 420);

    // R10: out-of-range writes under a small grid are dropped
    cur_req = "R10";
    reg_wr(3, (3 << 8) | 1); reg_wr(4, 0); reg_wr(5, 0);
    cm_wr(8, 16'hFF03);
    cm_wr(100, 16'hFFE0);
    cm_wr(7, 16'hFF1C);
    reg_wr(3, (63 << 8) | 31);
    reg_wr(2, 16'h0008);
    scan(84, 110, 0, 17);
    scan(420, 445, 18, 35);

    // R11: fetch and write to the same word on one edge
    cur_req = "R11";
    reg_wr(3, (3 << 8) | 0);
    cm_wr(1, 16'hFFE0);
    @(negedge clk);
    x_i = 11'd13; y_i = 11'd2; pix_i = 24'h406080; valid_i = 1'b1;
    repeat (2) @(negedge clk);
    cm_we = 1'b1; cm_addr = 11'd1; cm_wdata = 16'h0000;
    @(negedge clk); cm_we = 1'b0;
    repeat (4) @(negedge clk);
    valid_i = 1'b0;
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule